// File: doc/BRIEF.md
# Programmable Trigger Timing Generator

This block turns a one-cycle trigger accept into four timed outputs: a
first-level trigger pulse with a programmable width, two detector-chamber
trigger pulses with their own programmable delays, and a one-cycle sampling
strobe. The strobe tells external multiplicity counters when to capture their
sector counts. All timing comes from one packed 32-bit control word. The word
is sampled in the same clock edge that accepts the trigger.

The clock runs at 200 MHz, so one cycle is 5 ns. Chamber delays are counted in
coarse steps of 4 cycles (20 ns). The strobe delay and the first-level width
are counted in single cycles. The first-level width follows a split rule:

- Width codes below 7 add a fixed base of 21 cycles (105 ns).
- Width codes of 7 and above give the code itself as the number of cycles.

A busy flag stays high while any output is still counting. A trigger that
arrives while the flag is high is dropped.

All output timing below is measured from the accept edge, written T. The
accept edge is the rising clock edge at which `trig_i` is high while `busy_o`
is low. An output that "rises at T+n" is first high in the cycle after edge
T+n.

Top module: `trig_timing_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `l1_pulse_o`, `chamb_a_o`, `chamb_b_o`, `mult_strobe_o` and `busy_o` are all low.
- R2: The first-level pulse rises at T. When the width code in control bits 31..28 is below 7, the pulse stays high for 21 plus the code cycles. Code 0 therefore gives 21 cycles.
- R3: When the width code in bits 31..28 is 7 or more, the first-level pulse stays high for exactly the code's value in cycles (7 to 15).
- R4: `chamb_a_o` rises at T plus 4 times the 5-bit delay code in bits 21..17. A code of 0 makes it rise at T.
- R5: `chamb_b_o` rises at T plus 4 times the 5-bit delay code in bits 16..12. Its delay is independent of `chamb_a_o`.
- R6: Each chamber pulse stays high for exactly 4 cycles.
- R7: `mult_strobe_o` is high for exactly one cycle. It rises at T plus 6 plus the 4-bit code in bits 3..0.
- R8: `busy_o` rises at T and falls in the same edge as the last output to fall. A trigger that arrives while `busy_o` is high produces no output pulse. A trigger in the first cycle after `busy_o` falls is accepted.
- R9: Changes to `ctrl_word_i` after T have no effect on the running sequence. Bits 27..22 and 11..4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger accept, one cycle |
| ctrl_word_i | input | 32 | Packed timing control word |
| l1_pulse_o | output | 1 | First-level trigger pulse |
| chamb_a_o | output | 1 | First chamber-pair trigger |
| chamb_b_o | output | 1 | Second chamber-pair trigger |
| mult_strobe_o | output | 1 | Multiplicity sampling strobe |
| busy_o | output | 1 | Sequence in progress |

## Verification
The first-level pulse and both chamber pulses can all rise in the accept cycle. This happens when both chamber delay codes are zero, and the bench checks the start cycle and width of each pulse separately.

The end of one sequence can coincide with the accept of the next one. The bench drives the next trigger in the cycle right after `busy_o` falls and expects it to be accepted. A second trigger sent two cycles into a running sequence must add no pulse. Any extra or missing pulse shows up as an unmatched scoreboard entry.

// File: rtl/trig_timing_pkg.sv
package trig_timing_pkg;

    localparam int CNT_W           = 8;
    localparam int N_OUT           = 4;
    localparam int COARSE_CYC      = 4;
    localparam int STROBE_BASE_CYC = 6;
    localparam int L1_BASE_CYC     = 21;
    localparam int L1_SPLIT_CODE   = 7;
    localparam int CHAMB_WIDTH_CYC = 4;

    localparam int IDX_L1  = 0;
    localparam int IDX_CHA = 1;
    localparam int IDX_CHB = 2;
    localparam int IDX_STB = 3;

    typedef struct packed {
        logic [3:0] l1_code;
        logic [4:0] cha_dly;
        logic [4:0] chb_dly;
        logic [3:0] stb_dly;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] delay;
        logic [CNT_W-1:0] width;
    } timing_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.l1_code = w[31:28];
        c.cha_dly = w[21:17];
        c.chb_dly = w[16:12];
        c.stb_dly = w[3:0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] l1_width(input logic [3:0] code);
        if (int'(code) < L1_SPLIT_CODE)
            return CNT_W'(L1_BASE_CYC) + CNT_W'(code);
        else
            return CNT_W'(code);
    endfunction

    function automatic logic [CNT_W-1:0] coarse_delay(input logic [4:0] code);
        return CNT_W'(code) * CNT_W'(COARSE_CYC);
    endfunction

endpackage

// File: rtl/trig_ctrl_decode.sv
module trig_ctrl_decode
    import trig_timing_pkg::*;
(
    input  logic [31:0]            word_i,
    output timing_t [N_OUT-1:0]    tim_o
);
    ctrl_t c;

    always_comb begin
        c = unpack_ctrl(word_i);
        tim_o[IDX_L1].delay  = '0;
        tim_o[IDX_L1].width  = l1_width(c.l1_code);
        tim_o[IDX_CHA].delay = coarse_delay(c.cha_dly);
        tim_o[IDX_CHA].width = CNT_W'(CHAMB_WIDTH_CYC);
        tim_o[IDX_CHB].delay = coarse_delay(c.chb_dly);
        tim_o[IDX_CHB].width = CNT_W'(CHAMB_WIDTH_CYC);
        tim_o[IDX_STB].delay = CNT_W'(STROBE_BASE_CYC) + CNT_W'(c.stb_dly);
        tim_o[IDX_STB].width = CNT_W'(1);
    end
endmodule

// File: rtl/trig_delayed_pulse.sv
module trig_delayed_pulse
    import trig_timing_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] delay_i,
    input  logic [W-1:0] width_i,
    output logic         pulse_o,
    output logic         active_o
);
    phase_e       phase_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] width_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            width_q <= '0;
            pulse_o <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        width_q <= width_i;
                        if (delay_i == '0) begin
                            phase_q <= PH_HIGH;
                            cnt_q   <= width_i;
                            pulse_o <= 1'b1;
                        end else begin
                            phase_q <= PH_WAIT;
                            cnt_q   <= delay_i;
                        end
                    end
                end
                PH_WAIT: begin
                    if (cnt_q == W'(1)) begin
                        phase_q <= PH_HIGH;
                        cnt_q   <= width_q;
                        pulse_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == W'(1)) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        pulse_o <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - W'(1);
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    pulse_o <= 1'b0;
                end
            endcase
        end
    end

    assign active_o = (phase_q != PH_IDLE);
endmodule

// File: rtl/trig_timing_gen.sv
module trig_timing_gen
    import trig_timing_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        trig_i,
    input  logic [31:0] ctrl_word_i,
    output logic        l1_pulse_o,
    output logic        chamb_a_o,
    output logic        chamb_b_o,
    output logic        mult_strobe_o,
    output logic        busy_o
);
    timing_t [N_OUT-1:0] tim;
    logic    [N_OUT-1:0] pulse;
    logic    [N_OUT-1:0] active;
    logic                start;

    assign start = trig_i & ~busy_o;

    trig_ctrl_decode u_decode (
        .word_i (ctrl_word_i),
        .tim_o  (tim)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        trig_delayed_pulse #(.W(CNT_W)) u_pulse (
            .clk      (clk),
            .rst      (rst),
            .start_i  (start),
            .delay_i  (tim[g].delay),
            .width_i  (tim[g].width),
            .pulse_o  (pulse[g]),
            .active_o (active[g])
        );
    end

    assign busy_o        = |active;
    assign l1_pulse_o    = pulse[IDX_L1];
    assign chamb_a_o     = pulse[IDX_CHA];
    assign chamb_b_o     = pulse[IDX_CHB];
    assign mult_strobe_o = pulse[IDX_STB];
endmodule

// File: rtl/trig_timing_chk.sv
module trig_timing_chk (
    input logic        clk,
    input logic        rst,
    input logic        trig_i,
    input logic [31:0] ctrl_word_i,
    input logic        l1_pulse_o,
    input logic        chamb_a_o,
    input logic        chamb_b_o,
    input logic        mult_strobe_o,
    input logic        busy_o
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !(l1_pulse_o || chamb_a_o || chamb_b_o || mult_strobe_o || busy_o));

    a_r2_l1_on_accept: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !busy_o) |=> (l1_pulse_o && busy_o));

    a_r3_l1_min_width: assert property (@(posedge clk) disable iff (rst)
        $rose(l1_pulse_o) |=> l1_pulse_o ##1 l1_pulse_o ##1 l1_pulse_o
                              ##1 l1_pulse_o ##1 l1_pulse_o ##1 l1_pulse_o);

    a_r6_cha_width: assert property (@(posedge clk) disable iff (rst)
        $rose(chamb_a_o) |=> chamb_a_o ##1 chamb_a_o ##1 chamb_a_o ##1 !chamb_a_o);

    a_r6_chb_width: assert property (@(posedge clk) disable iff (rst)
        $rose(chamb_b_o) |=> chamb_b_o ##1 chamb_b_o ##1 chamb_b_o ##1 !chamb_b_o);

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        mult_strobe_o |=> !mult_strobe_o);

    a_r8_busy_covers: assert property (@(posedge clk) disable iff (rst)
        (l1_pulse_o || chamb_a_o || chamb_b_o || mult_strobe_o) |-> busy_o);

    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !l1_pulse_o) |=> !$rose(l1_pulse_o));
endmodule

bind trig_timing_gen trig_timing_chk chk_i (.*);

// File: tb/trig_timing_gen_tb_top.sv
module trig_timing_gen_tb_top;
    typedef struct {
        int    start;
        int    width;
        string tag;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_i = 1'b0;
    logic [31:0] ctrl_word_i = '0;
    logic        l1_pulse_o, chamb_a_o, chamb_b_o, mult_strobe_o, busy_o;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    ev_t  q_l1[$], q_a[$], q_b[$], q_s[$];
    logic [3:0] prev_o = '0;
    int   rise_c [4];

    always #10 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    trig_timing_gen dut_i (
        .clk(clk), .rst(rst), .trig_i(trig_i), .ctrl_word_i(ctrl_word_i),
        .l1_pulse_o(l1_pulse_o), .chamb_a_o(chamb_a_o), .chamb_b_o(chamb_b_o),
        .mult_strobe_o(mult_strobe_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input int l1, input int a,
                                            input int b, input int s);
        return {4'(l1), 6'h2B, 5'(a), 5'(b), 8'hA5, 4'(s)};
    endfunction

    task automatic pop_cmp(input int id, input int rs, input int fl);
        ev_t e;
        string nm;
        int sz;
        case (id)
            0: sz = q_l1.size();
            1: sz = q_a.size();
            2: sz = q_b.size();
            default: sz = q_s.size();
        endcase
        nm = (id == 0) ? "l1" : (id == 1) ? "cha" : (id == 2) ? "chb" : "strobe";
        if (sz == 0) begin
            chk(1'b0, "R8", {nm, " unexpected pulse start"}, rs, -1);
            return;
        end
        case (id)
            0: e = q_l1.pop_front();
            1: e = q_a.pop_front();
            2: e = q_b.pop_front();
            default: e = q_s.pop_front();
        endcase
        chk(rs == e.start, e.tag, {nm, " start cycle"}, rs, e.start);
        chk(fl - rs == e.width, e.tag, {nm, " width"}, fl - rs, e.width);
    endtask

    // monitor
    always @(negedge clk) begin
        logic [3:0] cur;
        cur = {mult_strobe_o, chamb_b_o, chamb_a_o, l1_pulse_o};
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                if (cur[i] && !prev_o[i]) rise_c[i] = cyc;
                if (!cur[i] && prev_o[i]) pop_cmp(i, rise_c[i], cyc);
            end
        end
        prev_o = rst ? 4'b0 : cur;
    end

    // driver: call on a negedge; returns on the negedge where busy has fallen
    task automatic run_trig(input int l1, input int a, input int b, input int s,
                            input bit poke, input bit rewrite);
        int t, w, e_end;
        ev_t e;
        ctrl_word_i = mk_word(l1, a, b, s);
        trig_i = 1'b1;
        t = cyc + 1;
        w = (l1 < 7) ? 21 + l1 : l1;
        e.tag = (l1 < 7) ? "R2" : "R3"; e.start = t;         e.width = w; q_l1.push_back(e);
        e.tag = "R4";  e.start = t + 4*a;     e.width = 4; q_a.push_back(e);
        e.tag = "R5";  e.start = t + 4*b;     e.width = 4; q_b.push_back(e);
        e.tag = "R7";  e.start = t + 6 + s;   e.width = 1; q_s.push_back(e);
        e_end = t + w;
        if (t + 4*a + 4 > e_end) e_end = t + 4*a + 4;
        if (t + 4*b + 4 > e_end) e_end = t + 4*b + 4;
        if (t + 7 + s > e_end)   e_end = t + 7 + s;
        @(negedge clk);
        trig_i = 1'b0;
        if (rewrite) ctrl_word_i = mk_word(15 - l1, 31 - a, 31 - b, 15 - s); // R9
        if (poke) begin
            while (cyc < t + 2) @(negedge clk);
            chk(busy_o == 1'b1, "R8", "busy during run", int'(busy_o), 1);
            ctrl_word_i = mk_word(0, 0, 0, 0);
            trig_i = 1'b1;
            @(negedge clk);
            trig_i = 1'b0;
        end
        while (cyc < e_end - 1) @(negedge clk);
        chk(busy_o == 1'b1, "R8", "busy before last fall", int'(busy_o), 1);
        @(negedge clk);
        chk(busy_o == 1'b0, "R8", "busy after last fall", int'(busy_o), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({l1_pulse_o, chamb_a_o, chamb_b_o, mult_strobe_o, busy_o} == 5'b0,
            "R1", "outputs in reset",
            int'({l1_pulse_o, chamb_a_o, chamb_b_o, mult_strobe_o, busy_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({l1_pulse_o, chamb_a_o, chamb_b_o, mult_strobe_o, busy_o} == 5'b0,
            "R1", "outputs after reset",
            int'({l1_pulse_o, chamb_a_o, chamb_b_o, mult_strobe_o, busy_o}), 0);
        run_trig(0, 0, 0, 0, 1'b0, 1'b0);    // R2 code 0, all coincide
        run_trig(6, 3, 5, 15, 1'b0, 1'b0);   // R2 top of low branch
        run_trig(7, 31, 1, 2, 1'b0, 1'b1);   // R3 split, R4 max delay, R9 rewrite
        run_trig(15, 2, 9, 4, 1'b1, 1'b0);   // R3 max, R8 poke while busy
        run_trig(3, 1, 0, 9, 1'b1, 1'b1);    // R5 independent, R9 + R8
        run_trig(10, 0, 6, 0, 1'b0, 1'b0);   // R6 widths, back-to-back accept
        repeat (40) @(negedge clk);
        chk(q_l1.size() + q_a.size() + q_b.size() + q_s.size() == 0, "R8",
            "unmatched expected pulses",
            q_l1.size() + q_a.size() + q_b.size() + q_s.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule